// File: doc/BRIEF.md
# I2C Bus-Busy Monitor and Start/Stop Request Issuer

This block watches the two I2C lines and keeps a bus-busy flag that follows the conditions actually seen on the wire: a start condition sets it, a stop condition clears it. Both lines pass through a two-flop synchronizer. Start and stop are found by comparing each synchronized sample with the one taken a clock earlier.

The same busy flag also acts as the command port for a bit-level line driver. Software writes a busy value together with a companion control bit. With the control bit at 0, a write of busy=1 asks for a start condition, or for a repeated start if the flag already shows the bus as held. A write of busy=0 asks for a stop condition. The mode bits gate these writes. In slave mode every write is ignored, and a start is accepted only when both the master bit and the transmit bit are set. An accepted command leaves the block as a one-cycle request pulse. The flag itself moves only when the resulting condition shows up on the lines.

Two state machines do the work. The line-state machine has the states BUS_FREE and BUS_HELD. It moves BUS_FREE→BUS_HELD on a detected start and BUS_HELD→BUS_FREE on a detected stop. A start seen while already in BUS_HELD is a repeated start and keeps the machine in BUS_HELD. The request machine has the states REQ_IDLE, REQ_START, REQ_RSTART and REQ_STOP. Each accepted write moves it into the matching request state for exactly one cycle. Every cycle without an accepted write returns it to REQ_IDLE.

Top module: `i2c_busy_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, busy_o is 0 and start_req_o, rstart_req_o and stop_req_o are all 0.
- R2: SDA falling while SCL stays high sets busy_o to 1 no later than the third rising clock edge after the pin change.
- R3: SDA rising while SCL stays high clears busy_o to 0 no later than the third rising clock edge after the pin change.
- R4: A change of SDA while SCL is low leaves busy_o unchanged.
- R5: A write (wr_en_i=1) with wr_busy_i=1 and wr_ctl_i=0, while mode_master_i=1, mode_xmit_i=1 and busy_o=0, gives start_req_o=1 in the cycle after the write edge.
- R6: The same write while busy_o=1 gives rstart_req_o=1, with start_req_o=0, in the cycle after the write edge.
- R7: A write with wr_busy_i=0 and wr_ctl_i=0 while mode_master_i=1 gives stop_req_o=1 in the cycle after the write edge.
- R8: With mode_master_i=0, every write produces no request pulse.
- R9: A start write with mode_master_i=1 and mode_xmit_i=0 produces no request pulse.
- R10: A write with wr_ctl_i=1 produces no request pulse, whatever wr_busy_i is.
- R11: Request pulses never change busy_o; it changes only on conditions seen on the lines.
- R12: Each request pulse lasts exactly one cycle per accepted write, and at most one of the three request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| mode_master_i | input | 1 | 1 = master mode, 0 = slave mode |
| mode_xmit_i | input | 1 | 1 = transmit, 0 = receive |
| wr_en_i | input | 1 | One-cycle strobe of a busy/control write |
| wr_busy_i | input | 1 | Busy value carried by the write |
| wr_ctl_i | input | 1 | Companion control bit; must be 0 for a command |
| busy_o | output | 1 | Bus-busy flag seen on the wire |
| start_req_o | output | 1 | One-cycle start request to the line driver |
| rstart_req_o | output | 1 | One-cycle repeated-start request to the line driver |
| stop_req_o | output | 1 | One-cycle stop request to the line driver |

## Verification
The bench issues a start write on a free bus and then one on a held bus. A design that skipped the repeated-start case would pulse start_req_o on a held bus. It toggles SDA while SCL is low, both upward and downward, and a design that ignored the SCL level would set or clear busy on ordinary data bits. It sends writes in slave mode, in receive mode and with the control bit set, and a design that skipped any of these gates would leak a request pulse. Back-to-back accepted writes check that each pulse lasts exactly one cycle and that the request flag never moves busy_o on its own. A design that stretched a pulse or set the flag from the write would show an extra pulse or an early busy.

// File: rtl/i2c_busy_pkg.sv
package i2c_busy_pkg;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } line_state_e;

    typedef enum logic [1:0] {
        REQ_IDLE   = 2'd0,
        REQ_START  = 2'd1,
        REQ_RSTART = 2'd2,
        REQ_STOP   = 2'd3
    } req_state_e;

    localparam int unsigned LINE_COUNT = 2;
    localparam int unsigned LINE_SCL   = 0;
    localparam int unsigned LINE_SDA   = 1;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw_i[b]};
            end
        end

        assign sync_o[b] = chain_q[LAST];
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_seen_o,
    output logic stop_seen_o
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    always_comb begin
        start_seen_o = scl_prev_q && scl_s && sda_prev_q && !sda_s;
        stop_seen_o  = scl_prev_q && scl_s && !sda_prev_q && sda_s;
    end

endmodule

// File: rtl/i2c_line_fsm.sv
module i2c_line_fsm
    import i2c_busy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_seen_i,
    input  logic stop_seen_i,
    output logic busy_o
);
    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_FREE: if (start_seen_i) state_d = BUS_HELD;
            BUS_HELD: if (stop_seen_i)  state_d = BUS_FREE;
            default:  state_d = BUS_FREE;
        endcase
    end

    always_comb begin
        busy_o = (state_q == BUS_HELD);
    end

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_seen_i));

    assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(stop_seen_i));

endmodule

// File: rtl/i2c_req_fsm.sv
module i2c_req_fsm
    import i2c_busy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_master_i,
    input  logic mode_xmit_i,
    input  logic wr_en_i,
    input  logic wr_busy_i,
    input  logic wr_ctl_i,
    input  logic busy_i,
    output logic start_req_o,
    output logic rstart_req_o,
    output logic stop_req_o
);
    req_state_e state_q;
    req_state_e state_d;
    logic       cmd_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cmd_ok  = wr_en_i && !wr_ctl_i && mode_master_i;
        state_d = REQ_IDLE;
        unique case (state_q)
            REQ_IDLE, REQ_START, REQ_RSTART, REQ_STOP: begin
                if (cmd_ok && wr_busy_i && mode_xmit_i) begin
                    state_d = busy_i ? REQ_RSTART : REQ_START;
                end else if (cmd_ok && !wr_busy_i) begin
                    state_d = REQ_STOP;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        start_req_o  = (state_q == REQ_START);
        rstart_req_o = (state_q == REQ_RSTART);
        stop_req_o   = (state_q == REQ_STOP);
    end

    assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req_o, rstart_req_o, stop_req_o}));

    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req_o || rstart_req_o || stop_req_o) |-> $past(mode_master_i && wr_en_i));

    assert_start_needs_xmit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req_o || rstart_req_o) |-> $past(mode_xmit_i && wr_busy_i));

    assert_ctl_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req_o || rstart_req_o || stop_req_o) |-> $past(!wr_ctl_i));

    assert_fresh_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_req_o |-> $past(!busy_i));

    assert_held_rstart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_req_o |-> $past(busy_i));

endmodule

// File: rtl/i2c_busy_ctrl.sv
module i2c_busy_ctrl
    import i2c_busy_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic mode_master_i,
    input  logic mode_xmit_i,
    input  logic wr_en_i,
    input  logic wr_busy_i,
    input  logic wr_ctl_i,
    output logic busy_o,
    output logic start_req_o,
    output logic rstart_req_o,
    output logic stop_req_o
);
    logic [LINE_COUNT-1:0] raw_lines;
    logic [LINE_COUNT-1:0] sync_lines;
    logic                  start_seen;
    logic                  stop_seen;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    i2c_pin_sync #(
        .WIDTH  (LINE_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_lines),
        .sync_o (sync_lines)
    );

    i2c_cond_detect u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (sync_lines[LINE_SCL]),
        .sda_s        (sync_lines[LINE_SDA]),
        .start_seen_o (start_seen),
        .stop_seen_o  (stop_seen)
    );

    i2c_line_fsm u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_seen_i (start_seen),
        .stop_seen_i  (stop_seen),
        .busy_o       (busy_o)
    );

    i2c_req_fsm u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_master_i (mode_master_i),
        .mode_xmit_i   (mode_xmit_i),
        .wr_en_i       (wr_en_i),
        .wr_busy_i     (wr_busy_i),
        .wr_ctl_i      (wr_ctl_i),
        .busy_i        (busy_o),
        .start_req_o   (start_req_o),
        .rstart_req_o  (rstart_req_o),
        .stop_req_o    (stop_req_o)
    );

    assert_req_keeps_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req_o || stop_req_o) |-> $stable(busy_o) || $past(start_seen || stop_seen));

endmodule

// File: tb/i2c_busy_ctrl_test.sv
module i2c_busy_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1;
    logic sda_i = 1'b1;
    logic mode_master_i = 1'b0;
    logic mode_xmit_i = 1'b0;
    logic wr_en_i = 1'b0;
    logic wr_busy_i = 1'b0;
    logic wr_ctl_i = 1'b0;
    logic busy_o;
    logic start_req_o;
    logic rstart_req_o;
    logic stop_req_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int exp_q[$];
    string tag_q[$];

    localparam int K_NONE = 0, K_START = 1, K_RSTART = 2, K_STOP = 3, K_MULTI = 4;

    always #10 clk = ~clk;

    i2c_busy_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .mode_master_i(mode_master_i), .mode_xmit_i(mode_xmit_i),
        .wr_en_i(wr_en_i), .wr_busy_i(wr_busy_i), .wr_ctl_i(wr_ctl_i),
        .busy_o(busy_o), .start_req_o(start_req_o),
        .rstart_req_o(rstart_req_o), .stop_req_o(stop_req_o)
    );

    function automatic int observed();
        int n;
        n = int'(start_req_o) + int'(rstart_req_o) + int'(stop_req_o);
        if (n > 1) return K_MULTI;
        if (start_req_o) return K_START;
        if (rstart_req_o) return K_RSTART;
        if (stop_req_o) return K_STOP;
        return K_NONE;
    endfunction

    // Monitor: samples 5 ns after each rising edge, pops one expectation per driven write.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                int obs;
                obs = observed();
                if (exp_q.size() > 0) begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    tests++;
                    if (obs != e) begin
                        fails++;
                        $display("FAIL %s: request code %0d expected %0d", t, obs, e);
                    end
                end else if (obs != K_NONE) begin
                    tests++;
                    fails++;
                    $display("FAIL R12: unexpected request code %0d expected %0d", obs, K_NONE);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 5000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic write(input logic b, input logic c, input int exp, input string tag);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_busy_i = b;
        wr_ctl_i  = c;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic c, input logic d);
        @(negedge clk);
        scl_i = c;
        sda_i = d;
        idle(4);
    endtask

    task automatic check_busy(input logic exp, input string tag);
        tests++;
        if (busy_o !== exp) begin
            fails++;
            $display("FAIL %s: busy_o %0b expected %0b", tag, busy_o, exp);
        end
    endtask

    initial begin
        idle(3);
        // R1: reset state
        tests++;
        if ({busy_o, start_req_o, rstart_req_o, stop_req_o} !== 4'b0000) begin
            fails++;
            $display("FAIL R1: outputs %b expected %b",
                     {busy_o, start_req_o, rstart_req_o, stop_req_o}, 4'b0000);
        end
        rst_n = 1'b1;
        idle(2);
        check_busy(1'b0, "R1");

        mode_master_i = 1'b1;
        mode_xmit_i   = 1'b1;
        write(1'b1, 1'b0, K_START, "R5");
        idle(3);
        check_busy(1'b0, "R11");

        pins(1'b1, 1'b0);
        check_busy(1'b1, "R2");

        write(1'b1, 1'b0, K_RSTART, "R6");
        write(1'b0, 1'b0, K_STOP, "R7");
        idle(3);
        check_busy(1'b1, "R11");

        mode_master_i = 1'b0;
        write(1'b0, 1'b0, K_NONE, "R8");
        write(1'b1, 1'b0, K_NONE, "R8");
        mode_master_i = 1'b1;
        mode_xmit_i   = 1'b0;
        write(1'b1, 1'b0, K_NONE, "R9");
        write(1'b0, 1'b0, K_STOP, "R7");
        mode_xmit_i = 1'b1;
        write(1'b1, 1'b1, K_NONE, "R10");
        write(1'b0, 1'b1, K_NONE, "R10");
        idle(2);
        check_busy(1'b1, "R10");

        pins(1'b0, 1'b0);
        pins(1'b0, 1'b1);
        pins(1'b1, 1'b1);
        check_busy(1'b1, "R4");
        pins(1'b0, 1'b1);
        pins(1'b0, 1'b0);
        pins(1'b1, 1'b0);
        check_busy(1'b1, "R4");

        pins(1'b1, 1'b1);
        check_busy(1'b0, "R3");

        pins(1'b0, 1'b1);
        pins(1'b0, 1'b0);
        pins(1'b1, 1'b0);
        check_busy(1'b0, "R4");

        // R12: back-to-back accepted writes, one pulse each
        @(negedge clk);
        wr_en_i = 1'b1; wr_busy_i = 1'b1; wr_ctl_i = 1'b0;
        exp_q.push_back(K_START); tag_q.push_back("R12");
        @(negedge clk);
        wr_busy_i = 1'b0;
        exp_q.push_back(K_STOP); tag_q.push_back("R12");
        @(negedge clk);
        wr_en_i = 1'b0;
        idle(4);

        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12: pending expectations %0d expected %0d", exp_q.size(), 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule